// File: doc/BRIEF.md
# Suspend Wake-up Resume Controller

This block decides whether a host controller is asleep, waking up, on probation, or fully running. In deep-sleep suspend it releases a shared, active-low wake pin and watches it. An external agent pulling that pin LOW starts a wake-up. The block then waits for a clock settle period and raises a sticky clock-ready interrupt. After that it opens a resume window of programmable length. The window is measured in time-base ticks and loaded from the upper half of a 32-bit power-down control register.

A wake-up is provisional. If software sets the run/stop bit while the window is open, the controller commits to normal operation. If the window runs out first, the controller goes back to suspend by itself. From normal operation, software clears run/stop and pulses a suspend request to put the controller back to sleep.

A small register port gives access to three words:
- word 0 holds run/stop in bit 0;
- word 1 holds the window count in bits 31:16;
- word 2 holds the clock-ready flag in bit 0.

The tick input is one clock cycle wide once per count unit, about 7.6 µs. The reset count of 1311 therefore gives roughly a 10 ms window, and the largest count gives roughly 500 ms.

Top module: `wake_resume_ctrl`

## Requirements
- R1: After reset the state is SUSPEND (code 0), run/stop is 0, the window count reads 1311 in bits 31:16 of word 1, the clock-ready flag is 0 and the wake pin is released.
- R2: In SUSPEND, a HIGH wake pin causes no wake-up, and a LOW level present at only one clock edge also causes none.
- R3: In SUSPEND, a wake pin held LOW is accepted once two consecutive synchronised samples are LOW. The state becomes CLK_SETTLE (code 1) at the fourth clock edge after the pin first goes LOW.
- R4: The wake pin output enable is 0 in SUSPEND. In every other state the enable is 1 and the pin is driven LOW.
- R5: After exactly SETTLE_CYCLES clock edges in CLK_SETTLE, the state becomes RESUME_WINDOW (code 2). On the same edge the clock-ready flag (bit 0 of word 2) becomes 1.
- R6: The clock-ready flag stays at 1 until a write to word 2 with bit 0 = 1. A write to word 2 with bit 0 = 0 leaves it at 1.
- R7: If run/stop is 1 in RESUME_WINDOW, the state becomes RUNNING (code 3) on the next clock edge. This holds at any point in the window, including its first and last tick.
- R8: With run/stop 0, RESUME_WINDOW lasts until the count loaded on entry has been ticked down to zero, and the state returns to SUSPEND on the next edge. A count of 0 returns to SUSPEND on the first edge after entry.
- R9: Bits 31:16 of word 1 are writable and read back as written, and bits 15:0 of word 1 read 0.
- R10: In RUNNING, a suspend request pulse is ignored while run/stop is 1. With run/stop 0, the pulse moves the state to SUSPEND on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per resume count unit |
| wake_pin_in | input | 1 | Level sensed on the shared wake pin |
| wake_pin_oe | output | 1 | Output enable of the shared wake pin |
| wake_pin_out | output | 1 | Value driven on the wake pin when enabled (always 0) |
| susp_req | input | 1 | Suspend request strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 command, 1 power-down control, 2 interrupt status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| clk_ready_irq | output | 1 | Sticky clock-ready interrupt |
| state_o | output | 2 | Current state code |

## Verification
The hardest situation to reach is a commit that races the end of the window. This is run/stop landing on the last tick before expiry, or a window of zero length that closes on the first edge after the settle period. To get there, the stimulus times every tick and register write from the fourth-edge wake acceptance and the known settle length. A table of window counts and commit points is then walked through repeated wake, settle and commit-or-expire cycles. Single-edge glitches on the wake pin are driven on their own, to show that the double-sample filter rejects them.

// File: rtl/wake_resume_ctrl.sv
module wake_resume_ctrl #(
  parameter int          SETTLE_CYCLES = 4000,
  parameter logic [15:0] CNT_RESET     = 16'd1311
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wake_pin_in,
  output logic        wake_pin_oe,
  output logic        wake_pin_out,
  input  logic        susp_req,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        clk_ready_irq,
  output logic [1:0]  state_o
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [1:0] S_SUSP = 2'd0, S_SETTLE = 2'd1, S_RESUME = 2'd2, S_RUN = 2'd3;

  logic [1:0]    st;
  logic [2:0]    wsync;
  logic [SW-1:0] settle_cnt;
  logic [15:0]   pd_cnt, timer;
  logic          run, irq;

  wire wake_seen   = ~wsync[1] & ~wsync[2];
  wire settle_done = settle_cnt == SW'(SETTLE_CYCLES - 1);
  wire wr_cmd      = reg_we && reg_addr == 2'd0;
  wire wr_pd       = reg_we && reg_addr == 2'd1;
  wire irq_clr     = reg_we && reg_addr == 2'd2 && reg_wdata[0];

  assign wake_pin_oe   = st != S_SUSP;
  assign wake_pin_out  = 1'b0;
  assign clk_ready_irq = irq;
  assign state_o       = st;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {31'd0, run};
      2'd1:    reg_rdata = {pd_cnt, 16'd0};
      2'd2:    reg_rdata = {31'd0, irq};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wsync <= 3'b111;
    else        wsync <= {wsync[1:0], wake_pin_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run    <= 1'b0;
      pd_cnt <= CNT_RESET;
    end else begin
      if (wr_cmd) run    <= reg_wdata[0];
      if (wr_pd)  pd_cnt <= reg_wdata[31:16];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          irq <= 1'b0;
    else if (st == S_SETTLE && settle_done) irq <= 1'b1;
    else if (irq_clr)                    irq <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              settle_cnt <= '0;
    else if (st == S_SETTLE) settle_cnt <= settle_cnt + 1'b1;
    else                     settle_cnt <= '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_SUSP;
      timer <= '0;
    end else begin
      case (st)
        S_SUSP:   if (wake_seen) st <= S_SETTLE;
        S_SETTLE: if (settle_done) begin
                    st    <= S_RESUME;
                    timer <= pd_cnt;
                  end
        S_RESUME: if (run)              st    <= S_RUN;
                  else if (timer == 0)  st    <= S_SUSP;
                  else if (tick)        timer <= timer - 1'b1;
        S_RUN:    if (susp_req && !run) st    <= S_SUSP;
        default:  st <= S_SUSP;
      endcase
    end
  end

  p_stay_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP && wsync[1]) |=> st == S_SUSP);
  p_settle_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && settle_done) |=> (irq && st == S_RESUME));
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESUME && run) |=> st == S_RUN);
  p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESUME && !run && timer == 0) |=> st == S_SUSP);
  p_hold_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && run) |=> st == S_RUN);
endmodule

// File: tb/tb_wake_resume_ctrl.sv
module tb_wake_resume_ctrl;
  localparam int SETTLE = 8;

  logic clk = 0, rst_n = 0, tick = 0, pin = 1, susp_req = 0, we = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        oe, pout, irq;
  logic [31:0] rdata;
  logic [1:0]  st;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wake_resume_ctrl #(.SETTLE_CYCLES(SETTLE), .CNT_RESET(16'd1311)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wake_pin_in(pin),
    .wake_pin_oe(oe), .wake_pin_out(pout), .susp_req(susp_req),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .clk_ready_irq(irq), .state_o(st));

  // {count[26:11], ticks before commit[10:3], commit[2], expected state[1:0]}
  localparam logic [26:0] VEC [6] = '{
    {16'd5, 8'd2, 1'b1, 2'd3},
    {16'd5, 8'd0, 1'b1, 2'd3},
    {16'd4, 8'd3, 1'b1, 2'd3},
    {16'd3, 8'd0, 1'b0, 2'd0},
    {16'd1, 8'd0, 1'b0, 2'd0},
    {16'd0, 8'd0, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1;
    @(posedge clk); #1 tick = 0;
  endtask

  task automatic wake_and_settle();
    @(negedge clk); pin = 0;
    repeat (4) @(posedge clk); #1;
    chk("R3 settle entered", st, 1);
    chk("R4 pin driven", {oe, pout}, 2'b10);
    pin = 1;
    repeat (SETTLE - 1) @(posedge clk); #1;
    chk("R5 still settling", {st, irq}, {2'd1, 1'b0});
    @(posedge clk); #1;
    chk("R5 window and irq", {st, irq}, {2'd2, 1'b1});
  endtask

  task automatic back_to_sleep();
    wr(0, 0);
    @(negedge clk); susp_req = 1;
    @(posedge clk); #1 susp_req = 0;
    chk("R10 suspend from running", st, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 state", st, 0);
    chk("R1 pin released", oe, 0);
    chk("R1 irq", irq, 0);
    rd(1, d); chk("R1 count", d, {16'd1311, 16'd0});
    rd(0, d); chk("R1 run", d, 0);

    wr(1, 32'hABCD_1234);
    rd(1, d); chk("R9 count readback", d, 32'hABCD_0000);

    repeat (10) @(posedge clk); #1;
    chk("R2 high pin stays asleep", st, 0);
    @(negedge clk); pin = 0;
    @(negedge clk); pin = 1;
    repeat (8) @(posedge clk); #1;
    chk("R2 glitch ignored", st, 0);
    chk("R4 pin released in suspend", oe, 0);

    for (int i = 0; i < 6; i++) begin
      logic [15:0] cnt;
      logic [7:0]  t;
      cnt = VEC[i][26:11];
      t   = VEC[i][10:3];
      wr(1, {cnt, 16'd0});
      wake_and_settle();
      if (VEC[i][2]) begin
        repeat (int'(t)) pulse_tick();
        #1 chk("R7 window open before commit", st, 2);
        wr(0, 1);
        @(posedge clk); #1;
        chk("R7 commit", st, VEC[i][1:0]);
        chk("R4 pin driven running", oe, 1);
        back_to_sleep();
      end else begin
        if (cnt > 0) begin
          repeat (int'(cnt) - 1) pulse_tick();
          #1 chk("R8 window still open", st, 2);
          pulse_tick();
        end
        @(posedge clk); #1;
        chk("R8 expiry", st, VEC[i][1:0]);
      end
      wr(2, 1);
      chk("R6 irq cleared", irq, 0);
    end

    wr(1, {16'd20, 16'd0});
    wake_and_settle();
    wr(2, 0);
    chk("R6 write 0 keeps irq", irq, 1);
    rd(2, d); chk("R6 irq readable", d, 1);
    wr(2, 1);
    chk("R6 write 1 clears irq", irq, 0);
    wr(0, 1);
    @(posedge clk); #1;
    chk("R7 commit", st, 3);
    @(negedge clk); susp_req = 1;
    @(posedge clk); #1 susp_req = 0;
    repeat (2) @(posedge clk); #1;
    chk("R10 request ignored while run", st, 3);
    back_to_sleep();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule